// File: doc/BRIEF.md
# Sense-Reversing Barrier Synchronizer

This block holds a group of agents at a common meeting point until every one of them has arrived. Each agent has a one-cycle arrive pulse input and a release level output. An agent's release output is high while it is free to run. After it pulses arrive, the output drops, and it stays low until the last member of the group has arrived. When the group is complete, every waiting agent is freed in the same cycle.

Internally each agent owns a private polarity bit. The bit flips when the agent's arrival is accepted. A shared arrival counter adds up the accepted arrivals. It counts several arrivals in one cycle as one atomic step, so no arrival is lost. The arrival that brings the count to the group size clears the counter and turns the shared episode flag to the new polarity.

An agent waits exactly while its polarity differs from the flag. The flag is never reset between episodes, so the barrier can be reused in the very next cycle. An arrive pulse from an agent that is still waiting breaks the protocol. It is reported on a per-agent error output and otherwise discarded.

Top module: `sense_barrier`

## Requirements
- R1: After reset the counter is 0, the shared flag is 0 and every agent's polarity is 0, so every `release_o` bit is 1 and every `proto_err_o` bit is 0.
- R2: An accepted arrival of agent i inverts its polarity. If the group is not completed in that cycle, `release_o[i]` is 0 from the clock edge that samples the pulse.
- R3: A waiting agent's `release_o` bit stays 0 until the number of accepted arrivals in the current episode reaches `NUM_AGENTS`.
- R4: On the edge that accepts the completing arrival, the counter returns to 0 and the flag takes the new polarity. All `release_o` bits are then 1, including the bit of the completing agent.
- R5: All accepted arrivals sampled on the same edge are counted. If all `NUM_AGENTS` agents arrive in one cycle, the episode completes on that edge and no `release_o` bit ever drops.
- R6: An arrive pulse from an agent whose `release_o` is 0 is not counted and does not change its polarity. Its `proto_err_o` bit is 1 for exactly the one cycle after that edge.
- R7: The flag is never cleared between episodes. An agent may arrive in the cycle right after it is released, and the next episode works with the opposite polarity.
- R8: The arrival counter never reaches `NUM_AGENTS`. After `NUM_AGENTS`-1 accepted arrivals, the waiting agents are still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | NUM_AGENTS | One-cycle arrival pulse per agent |
| release_o | output | NUM_AGENTS | 1 = agent free to run, 0 = agent held at the barrier |
| proto_err_o | output | NUM_AGENTS | One-cycle pulse: arrival while still held |

## Verification
A wrong polarity bit makes an agent appear held or freed incorrectly. Because `release_o` is decoded straight from the polarity and flag registers, this shows on `release_o` right after the faulty edge. A counter that loses or double-counts arrivals first shows at the end of an episode. The release comes one arrival too late or too early, so checking every cycle across episodes of mixed batch sizes exposes it within one episode. A flag that is wrongly cleared shows up in the following episode, when the polarity is reversed.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // Width of a counter able to hold 0..n
  function automatic int unsigned tally_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/arrive_tally.sv
module arrive_tally #(
  parameter int unsigned NUM_AGENTS = 4,
  localparam int unsigned CW = barrier_pkg::tally_width(NUM_AGENTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_AGENTS-1:0] accepted_i,
  output logic                  flag_q,
  output logic [CW-1:0]         count_q,
  output logic                  done_w
);
  // Number of set bits, widened by one bit so count+ones never overflows
  function automatic logic [CW:0] ones_of(input logic [NUM_AGENTS-1:0] v);
    logic [CW:0] s;
    s = '0;
    for (int i = 0; i < NUM_AGENTS; i++) s = s + {{CW{1'b0}}, v[i]};
    return s;
  endfunction

  logic [CW:0] sum_w;
  assign sum_w  = {1'b0, count_q} + ones_of(accepted_i);
  assign done_w = (sum_w == (CW+1)'(NUM_AGENTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      flag_q  <= 1'b0;
    end else if (done_w) begin
      count_q <= '0;
      flag_q  <= ~flag_q;
    end else begin
      count_q <= sum_w[CW-1:0];
    end
  end

  a_r8_count_below_p: assert property (@(posedge clk) disable iff (!rst_n)
    count_q < CW'(NUM_AGENTS));
  a_r4_flag_turns_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> (flag_q != $past(flag_q)) && (count_q == '0));
  a_r7_flag_held_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> $stable(flag_q));
endmodule

// File: rtl/sense_bank.sv
module sense_bank #(
  parameter int unsigned NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_AGENTS-1:0] arrive_i,
  input  logic                  flag_i,
  output logic [NUM_AGENTS-1:0] sense_q,
  output logic [NUM_AGENTS-1:0] waiting_w,
  output logic [NUM_AGENTS-1:0] accepted_w,
  output logic [NUM_AGENTS-1:0] err_q
);
  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_agent
    assign waiting_w[g]  = sense_q[g] ^ flag_i;
    assign accepted_w[g] = arrive_i[g] & ~waiting_w[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sense_q[g] <= 1'b0;
        err_q[g]   <= 1'b0;
      end else begin
        if (accepted_w[g]) sense_q[g] <= ~sense_q[g];
        err_q[g] <= arrive_i[g] & waiting_w[g];
      end
    end

    a_r2_sense_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      accepted_w[g] |=> sense_q[g] != $past(sense_q[g]));
    a_r6_dup_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (arrive_i[g] && waiting_w[g]) |=> $stable(sense_q[g]) && err_q[g]);
    a_r2_sense_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !accepted_w[g] |=> $stable(sense_q[g]));
  end
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
  parameter int unsigned NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_AGENTS-1:0] arrive_i,
  output logic [NUM_AGENTS-1:0] release_o,
  output logic [NUM_AGENTS-1:0] proto_err_o
);
  localparam int unsigned CW = barrier_pkg::tally_width(NUM_AGENTS);

  logic                  flag_w;
  logic [CW-1:0]         count_w;
  logic                  done_w;
  logic [NUM_AGENTS-1:0] sense_w, waiting_w, accepted_w, err_w;

  sense_bank #(.NUM_AGENTS(NUM_AGENTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive_i), .flag_i(flag_w),
    .sense_q(sense_w), .waiting_w(waiting_w), .accepted_w(accepted_w),
    .err_q(err_w)
  );

  arrive_tally #(.NUM_AGENTS(NUM_AGENTS)) u_tally (
    .clk(clk), .rst_n(rst_n), .accepted_i(accepted_w),
    .flag_q(flag_w), .count_q(count_w), .done_w(done_w)
  );

  assign release_o   = ~waiting_w;
  assign proto_err_o = err_w;

  a_r4_all_freed: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> (&release_o));
  a_r3_no_early_free: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> ($past(waiting_w) & ~waiting_w) == '0);
  a_r6_err_only_if_held: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive_i & waiting_w) == '0 |=> proto_err_o == '0);
endmodule

// File: tb/sense_barrier_tb.sv
module sense_barrier_tb;
  localparam int unsigned N = 4;
  localparam time CLK_PERIOD = 10;

  typedef struct {
    logic [N-1:0] rel;
    logic [N-1:0] err;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] arrive = '0;
  logic [N-1:0] release_o, proto_err_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t q[$];

  // reference state kept from the requirements
  logic [N-1:0] m_sense = '0;
  logic m_flag = 1'b0;
  int m_count = 0;

  sense_barrier #(.NUM_AGENTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive),
    .release_o(release_o), .proto_err_o(proto_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic [N-1:0] mask, input string tag);
    exp_t e;
    int n;
    logic [N-1:0] held, ok, dup;
    @(negedge clk);
    arrive = mask;
    held = '0;
    for (int i = 0; i < N; i++) held[i] = (m_sense[i] != m_flag);
    ok  = mask & ~held;
    dup = mask & held;
    n = 0;
    for (int i = 0; i < N; i++) if (ok[i]) n++;
    m_sense = m_sense ^ ok;
    if (m_count + n == N) begin
      m_count = 0;
      m_flag = ~m_flag;
    end else m_count = m_count + n;
    for (int i = 0; i < N; i++) e.rel[i] = (m_sense[i] == m_flag);
    e.err = dup;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (release_o !== e.rel || proto_err_o !== e.err) begin
          bad++;
          $display("FAIL %s: release=%b err=%b expected release=%b err=%b",
                   e.tag, release_o, proto_err_o, e.rel, e.err);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (release_o !== '1 || proto_err_o !== '0) begin
      bad++;
      $display("FAIL R1: release=%b err=%b expected release=%b err=%b",
               release_o, proto_err_o, {N{1'b1}}, {N{1'b0}});
    end
    rst_n = 1'b1;
    // episode one: staggered arrivals with a duplicate
    step(4'b0001, "R2");
    step(4'b0000, "R3");
    step(4'b0100, "R3");
    step(4'b0001, "R6");
    step(4'b0010, "R8");
    step(4'b1000, "R4");
    // episode two right after release, reversed polarity
    step(4'b0011, "R7");
    step(4'b1100, "R5");
    // all in one cycle
    step(4'b1111, "R5");
    // mixed: duplicates together with completing arrivals
    step(4'b0101, "R7");
    step(4'b1111, "R6");
    step(4'b0110, "R2");
    step(4'b0110, "R6");
    step(4'b0000, "R3");
    step(4'b1001, "R4");
    step(4'b0000, "R1");
    @(negedge clk);
    arrive = '0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule